// File: doc/BRIEF.md
# Cascadable Dual Pulse Counter

This block counts rising edges on two external event pins, each with its own 16-bit counter. Every pin passes through a two-flop synchronizer and an optional debounce filter before an edge is accepted. Software supplies a reference value per counter. When a counter steps into its reference, a sticky event flag is raised that can be used as an interrupt or a wake request. The flag stays set until software clears it. The counters wrap at the top of their range and keep counting after a match.

When the cascade control is set, the two counters act as one 32-bit counter. The first counter holds the low half and the second holds the high half. The combined counter is clocked only by the first pin and its enable. It is compared against the two reference values joined together, and any match is reported on the first event flag alone.

Top module: `pcnt_dual`

## Requirements
- R1: After reset both counts read 0 and both event flags read 0.
- R2: While a counter's enable is high, each rising edge on its pin adds one to its count. With debounce off, a pin that goes high between clock edges E0 and E1 shows up in the count after edge E3: two synchronizer flops plus one filter stage.
- R3: While a counter's enable is low, edges on its pin leave the count unchanged.
- R4: The shared 2-bit debounce code selects how many consecutive synchronized samples a new pin level must hold before it is accepted: code 0 needs 1 sample, code 1 needs 2, code 2 needs 4 and code 3 needs 8. A shorter pulse is not counted.
- R5: A 16-bit count of 0xFFFF goes to 0x0000 on the next accepted edge. It does not saturate.
- R6: An event flag is set when its counter increments into a value equal to its reference. Counting continues after the match.
- R7: No event is raised unless the count steps exactly into the reference value. Passing the reference without hitting it, or setting the reference equal to a count that is not moving, raises nothing.
- R8: An event flag stays set until its event-clear input is pulsed. Further edges do not change it.
- R9: A count-clear pulse sets that count to 0. It does not touch the event flag or the reference value.
- R10: With cascade high, {count_b, count_a} forms one 32-bit counter driven by pin_a and en_a. count_b advances only when count_a wraps. pin_b and en_b have no effect.
- R11: With cascade high, event_a is set when the 32-bit count steps into {ref_b, ref_a}, and event_b is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_a | input | 1 | Event pin for counter A (also feeds the 32-bit counter) |
| pin_b | input | 1 | Event pin for counter B |
| en_a | input | 1 | Count enable for counter A |
| en_b | input | 1 | Count enable for counter B (ignored in cascade) |
| dbnc | input | 2 | Debounce code: 0=1, 1=2, 2=4, 3=8 stable samples |
| cascade | input | 1 | Join both counters into one 32-bit counter |
| ref_a | input | 16 | Reference for counter A, or the low half of the 32-bit reference |
| ref_b | input | 16 | Reference for counter B, or the high half of the 32-bit reference |
| clr_a | input | 1 | Zero count A |
| clr_b | input | 1 | Zero count B |
| evt_clr_a | input | 1 | Clear event flag A |
| evt_clr_b | input | 1 | Clear event flag B |
| count_a | output | 16 | Count A |
| count_b | output | 16 | Count B |
| event_a | output | 1 | Sticky event flag A (the combined event in cascade) |
| event_b | output | 1 | Sticky event flag B |

## Verification
An accepted pin edge reaches the count and the event flag 2+N clock edges after the pin changes, where N is the number of samples the debounce code requires. That is 3 edges with debounce off and 10 with the 8-sample setting. One directed test samples the count on the falling edge just before and just after that point. All other checks come after a settle wait longer than the worst-case latency, with every pulse held high and low for longer than the debounce window in use. Clear inputs act one edge after they are driven, and their effect is read on the following falling edge.

// File: rtl/pcnt_pkg.sv
// Shared types for the dual pulse counter.
// Assumes: the debounce code is two bits wide and the sample counts are powers of two.
package pcnt_pkg;

    typedef enum logic [1:0] {
        DB_OFF = 2'd0,
        DB_2   = 2'd1,
        DB_4   = 2'd2,
        DB_8   = 2'd3
    } dbnc_e;

    // Number of consecutive samples a new level must hold before it is accepted.
    function automatic logic [3:0] dbnc_need(input dbnc_e code);
        case (code)
            DB_OFF:  dbnc_need = 4'd1;
            DB_2:    dbnc_need = 4'd2;
            DB_4:    dbnc_need = 4'd4;
            default: dbnc_need = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/pcnt_edge.sv
// Pin front end: a synchronizer chain, a stability filter and rising-edge detection.
// Does: emits a one-cycle 'rise' on the clock edge where a high level is accepted.
// Assumes: MAX_N >= 8 so the 8-sample setting fits in the stability counter.
module pcnt_edge
    import pcnt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_N       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] dbnc,
    output logic       rise
);
    localparam int SW = $clog2(MAX_N);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   s_lvl;
    logic                   acc_lvl;
    logic [SW-1:0]          stab_q;
    logic [3:0]             need;
    logic [SW-1:0]          lim;
    logic                   take;

    // Synchronizer chain that brings the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign s_lvl = sync_q[SYNC_STAGES-1];
    assign need  = dbnc_need(dbnc_e'(dbnc));
    assign lim   = SW'(need - 4'd1);
    assign take  = (s_lvl != acc_lvl) && (stab_q == lim);
    assign rise  = take && s_lvl;

    // Stability filter: a differing level must persist 'need' samples before it is adopted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_lvl <= 1'b0;
            stab_q  <= '0;
        end else if (s_lvl == acc_lvl) begin
            stab_q  <= '0;
        end else if (take) begin
            acc_lvl <= s_lvl;
            stab_q  <= '0;
        end else begin
            stab_q  <= stab_q + 1'b1;
        end
    end

    // R4: with a window of two or more samples, the adopted level was also present a sample earlier.
    p_db_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(acc_lvl) && ($past(need) >= 4'd2)) |-> ($past(s_lvl, 2) == acc_lvl));

endmodule

// File: rtl/pcnt_cell.sv
// One wrapping counter slice with reference comparison.
// Does: counts on 'inc', zeroes on 'clr' (clr has priority), and reports the
// reference match for the present value and for the value after an increment.
// Assumes: the parent uses eq_next only in a cycle where it also raises inc.
module pcnt_cell #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] ref_val,
    output logic [W-1:0] q,
    output logic         at_max,
    output logic         eq_next,
    output logic         eq_now
);
    logic [W-1:0] q_plus;

    assign q_plus  = q + 1'b1;
    assign at_max  = &q;
    assign eq_next = (q_plus == ref_val);
    assign eq_now  = (q == ref_val);

    // Count register: clear first, then increment with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (inc) q <= q_plus;
    end

    // R5: the all-ones value wraps to zero.
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && at_max) |=> (q == '0));
    // R3: without a count request or a clear the value holds.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(q));
    // R9: a clear leaves zero behind.
    p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

endmodule

// File: rtl/pcnt_dual.sv
// Two pulse counters with sticky reference events and an optional 32-bit cascade.
// Does: counts accepted rising edges per pin, sets a flag when a count steps
// into its reference, and in cascade mode chains the low slice's wrap into the high slice.
// Assumes: the reference, enable and mode inputs are quasi-static register values.
module pcnt_dual
    import pcnt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_N       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             en_a,
    input  logic             en_b,
    input  logic [1:0]       dbnc,
    input  logic             cascade,
    input  logic [CNT_W-1:0] ref_a,
    input  logic [CNT_W-1:0] ref_b,
    input  logic             clr_a,
    input  logic             clr_b,
    input  logic             evt_clr_a,
    input  logic             evt_clr_b,
    output logic [CNT_W-1:0] count_a,
    output logic [CNT_W-1:0] count_b,
    output logic             event_a,
    output logic             event_b
);
    localparam int NCH = 2;

    logic [NCH-1:0]       pins;
    logic [NCH-1:0]       ens;
    logic [NCH-1:0]       clrs;
    logic [NCH-1:0]       eclrs;
    logic [NCH-1:0]       rise;
    logic [NCH-1:0]       inc;
    logic [NCH-1:0]       at_max;
    logic [NCH-1:0]       eq_next;
    logic [NCH-1:0]       eq_now;
    logic [NCH-1:0]       set_evt;
    logic [NCH-1:0]       flag_q;
    logic [CNT_W-1:0]     refs  [NCH];
    logic [CNT_W-1:0]     cnts  [NCH];
    logic                 carry;
    logic                 hit_solo_a;
    logic                 hit_solo_b;
    logic                 hit_wide;

    assign pins  = {pin_b, pin_a};
    assign ens   = {en_b, en_a};
    assign clrs  = {clr_b, clr_a};
    assign eclrs = {evt_clr_b, evt_clr_a};
    assign refs[0] = ref_a;
    assign refs[1] = ref_b;

    // One front end and one counter slice per channel.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pcnt_edge #(.SYNC_STAGES(SYNC_STAGES), .MAX_N(MAX_N)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[i]),
            .dbnc (dbnc),
            .rise (rise[i])
        );
        pcnt_cell #(.W(CNT_W)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clrs[i]),
            .inc    (inc[i]),
            .ref_val(refs[i]),
            .q      (cnts[i]),
            .at_max (at_max[i]),
            .eq_next(eq_next[i]),
            .eq_now (eq_now[i])
        );
    end

    // Increment steering: the high slice follows its own pin or the low slice's wrap.
    always_comb begin
        inc[0] = ens[0] && rise[0];
        carry  = inc[0] && !clrs[0] && at_max[0];
        inc[1] = cascade ? carry : (ens[1] && rise[1]);
    end

    // Match detection for the separate and the joined arrangement.
    always_comb begin
        hit_solo_a = inc[0] && !clrs[0] && eq_next[0];
        hit_solo_b = inc[1] && !clrs[1] && eq_next[1];
        hit_wide   = inc[0] && !clrs[0] && !clrs[1] && eq_next[0]
                     && (carry ? eq_next[1] : eq_now[1]);
        set_evt[0] = cascade ? hit_wide : hit_solo_a;
        set_evt[1] = !cascade && hit_solo_b;
    end

    // Sticky flags: a new match sets, the clear input drops, otherwise hold.
    for (genvar j = 0; j < NCH; j++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[j] <= 1'b0;
            else if (set_evt[j]) flag_q[j] <= 1'b1;
            else if (eclrs[j])   flag_q[j] <= 1'b0;
        end
    end

    assign count_a = cnts[0];
    assign count_b = cnts[1];
    assign event_a = flag_q[0];
    assign event_b = flag_q[1];

    // R8: a flag without a clear request stays set.
    p_sticky_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (event_a && !evt_clr_a) |=> event_a);
    p_sticky_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (event_b && !evt_clr_b) |=> event_b);
    // R11: the second flag cannot rise while the counters are joined.
    p_casc_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && !event_b) |=> !event_b);
    // R10: in cascade the high half moves only on a wrap of the low half.
    p_casc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && !clr_b && !(count_a == '1)) |=> $stable(count_b));
    p_casc_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && !clr_a && !clr_b && en_a && rise[0] && (count_a == '1))
        |=> (count_b == $past(count_b) + 1'b1));
    // R1: the first cycle out of reset shows empty counts and flags.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (count_a == '0 && count_b == '0 && !event_a && !event_b));

endmodule

// File: tb/sim_pcnt_dual.sv
module sim_pcnt_dual;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pin_a, pin_b, en_a, en_b, cascade;
    logic [1:0]  dbnc;
    logic [15:0] ref_a, ref_b;
    logic        clr_a, clr_b, evt_clr_a, evt_clr_b;
    logic [15:0] count_a, count_b;
    logic        event_a, event_b;

    int n_chk  = 0;
    int n_err  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pcnt_dual u0 (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
        .en_a(en_a), .en_b(en_b), .dbnc(dbnc), .cascade(cascade),
        .ref_a(ref_a), .ref_b(ref_b), .clr_a(clr_a), .clr_b(clr_b),
        .evt_clr_a(evt_clr_a), .evt_clr_b(evt_clr_b),
        .count_a(count_a), .count_b(count_b), .event_a(event_a), .event_b(event_b)
    );

    typedef struct packed {
        logic [1:0]  db;
        logic        casc;
        logic [15:0] ra;
        logic [15:0] rb;
        logic [7:0]  na;
        logic [7:0]  nb;
        logic [15:0] xa;
        logic [15:0] xb;
        logic        fa;
        logic        fb;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{2'd0, 1'b0, 16'd3,  16'd5, 8'd3, 8'd2, 16'd3, 16'd2, 1'b1, 1'b0},
        '{2'd1, 1'b0, 16'd10, 16'd1, 8'd4, 8'd1, 16'd4, 16'd1, 1'b0, 1'b1},
        '{2'd3, 1'b0, 16'd2,  16'd2, 8'd5, 8'd2, 16'd5, 16'd2, 1'b1, 1'b1},
        '{2'd0, 1'b1, 16'd4,  16'd0, 8'd4, 8'd3, 16'd4, 16'd0, 1'b1, 1'b0},
        '{2'd0, 1'b1, 16'd7,  16'd0, 8'd2, 8'd0, 16'd2, 16'd0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int which, input int hi, input int lo);
        if (which == 0) pin_a = 1'b1; else pin_b = 1'b1;
        wait_n(hi);
        if (which == 0) pin_a = 1'b0; else pin_b = 1'b0;
        wait_n(lo);
    endtask

    task automatic pulses(input int which, input int n, input int hi, input int lo);
        for (int k = 0; k < n; k++) pulse(which, hi, lo);
    endtask

    task automatic clear_all();
        clr_a = 1'b1; clr_b = 1'b1; evt_clr_a = 1'b1; evt_clr_b = 1'b1;
        wait_n(1);
        clr_a = 1'b0; clr_b = 1'b0; evt_clr_a = 1'b0; evt_clr_b = 1'b0;
        wait_n(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; pin_a = 1'b0; pin_b = 1'b0; en_a = 1'b1; en_b = 1'b1;
        dbnc = 2'd0; cascade = 1'b0; ref_a = 16'hFFFF; ref_b = 16'hFFFF;
        clr_a = 1'b0; clr_b = 1'b0; evt_clr_a = 1'b0; evt_clr_b = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1 count_a", 32'(count_a), 32'd0);
        chk("R1 count_b", 32'(count_b), 32'd0);
        chk("R1 events", {30'd0, event_b, event_a}, 32'd0);

        // R2 latency: pin high at a falling edge, count moves on the third rising edge.
        pin_a = 1'b1;
        wait_n(2);
        chk("R2 before third edge", 32'(count_a), 32'd0);
        wait_n(1);
        chk("R2 after third edge", 32'(count_a), 32'd1);
        pin_a = 1'b0;
        wait_n(4);

        // Table of configurations walked by one loop.
        foreach (VEC[i]) begin
            dbnc = VEC[i].db; cascade = VEC[i].casc;
            ref_a = VEC[i].ra; ref_b = VEC[i].rb;
            clear_all();
            pulses(0, int'(VEC[i].na), 9, 10);
            pulses(1, int'(VEC[i].nb), 9, 10);
            wait_n(12);
            // R2, R4, R6, R10, R11 across the table
            chk($sformatf("R2/R10 vec%0d count_a", i), 32'(count_a), 32'(VEC[i].xa));
            chk($sformatf("R2/R10 vec%0d count_b", i), 32'(count_b), 32'(VEC[i].xb));
            chk($sformatf("R6/R11 vec%0d event_a", i), 32'(event_a), 32'(VEC[i].fa));
            chk($sformatf("R6/R11 vec%0d event_b", i), 32'(event_b), 32'(VEC[i].fb));
        end

        // R4: with the 8-sample setting a 7-cycle pulse is dropped, an 8-cycle pulse counts.
        dbnc = 2'd3; cascade = 1'b0; ref_a = 16'hFFFF; ref_b = 16'hFFFF;
        clear_all();
        pulse(0, 7, 12);
        chk("R4 short pulse ignored", 32'(count_a), 32'd0);
        pulse(0, 8, 12);
        chk("R4 full pulse counted", 32'(count_a), 32'd1);

        // R5, R10, R11: 32-bit cascade across the low-half wrap, reference 0x0001_0000.
        dbnc = 2'd0; cascade = 1'b1; ref_a = 16'h0000; ref_b = 16'h0001;
        clear_all();
        pulses(0, 65535, 1, 1);
        wait_n(4);
        chk("R10 low half full", 32'(count_a), 32'h0000FFFF);
        chk("R11 no early event", 32'(event_a), 32'd0);
        pulse(0, 1, 1);
        wait_n(4);
        chk("R5 low half wrapped", 32'(count_a), 32'd0);
        chk("R10 carry into high half", 32'(count_b), 32'd1);
        chk("R11 combined event", 32'(event_a), 32'd1);
        chk("R11 second flag quiet", 32'(event_b), 32'd0);

        // R6, R8: event at 3, counting continues, flag stays.
        cascade = 1'b0; ref_a = 16'd3; ref_b = 16'hFFFF;
        clear_all();
        pulses(0, 5, 2, 2);
        wait_n(4);
        chk("R6 counting continues", 32'(count_a), 32'd5);
        chk("R8 flag held", 32'(event_a), 32'd1);
        evt_clr_a = 1'b1; wait_n(1); evt_clr_a = 1'b0; wait_n(1);
        chk("R8 flag cleared", 32'(event_a), 32'd0);

        // R7: reference below the count, then equal to a still count.
        ref_a = 16'd2;
        pulses(0, 2, 2, 2);
        wait_n(4);
        chk("R7 count past reference", 32'(count_a), 32'd7);
        chk("R7 no event when passed", 32'(event_a), 32'd0);
        ref_a = 16'd7;
        wait_n(3);
        chk("R7 no event when static equal", 32'(event_a), 32'd0);

        // R9: count clear keeps the flag and the reference.
        ref_a = 16'd9;
        pulses(0, 2, 2, 2);
        wait_n(4);
        chk("R9 setup event", 32'(event_a), 32'd1);
        clr_a = 1'b1; wait_n(1); clr_a = 1'b0; wait_n(1);
        chk("R9 count zeroed", 32'(count_a), 32'd0);
        chk("R9 flag kept", 32'(event_a), 32'd1);
        evt_clr_a = 1'b1; wait_n(1); evt_clr_a = 1'b0;
        pulses(0, 9, 2, 2);
        wait_n(4);
        chk("R9 reference kept", {15'd0, event_a, count_a}, {15'd0, 1'b1, 16'd9});

        // R3: enable low blocks counting.
        en_a = 1'b0;
        pulses(0, 3, 2, 2);
        wait_n(4);
        chk("R3 disabled count held", 32'(count_a), 32'd9);
        en_a = 1'b1;

        finish_run();
    end
endmodule